// File: doc/BRIEF.md
# BCH error-location bit corrector

This block sits after a BCH decoder and repairs one data chunk held in a local byte buffer. A host loads the chunk through a byte-wide port. It then pulses a start input with the decoder's status word and the configured correction strength. The corrector reads the count of located errors and the decoder's verdict from that status word. For a correctable chunk it fetches packed location words from the decoder's result bank, one word at a time, and inverts each addressed bit in the buffer.

Every location word carries two 13-bit bit positions. The corrector walks only as many positions as the decoder reported. Any position that points past the end of the data unit (into spare or parity bytes) is passed over and leaves the data alone. When the run ends, the block holds the number of bits it flipped and a failure flag. The host reads the corrected chunk back through the same byte port.

Top module: `bch_bit_fixer`

## Requirements
- R1: After reset, busy_o, done_o, fail_o and fixed_cnt_o are all zero.
- R2: A location word carries its first location in bits 12:0 and its second in bits 28:16; bits 15:13 and 31:29 have no effect.
- R3: A location L inverts bit (L mod 8) of buffer byte (L div 8) and changes no other bit.
- R4: For a reported count n, the block reads words 0 to (n+1)/2-1 in order and applies the first location before the second. The second location of the last word is applied only when n is even.
- R5: A location whose byte index is equal to or greater than UNIT_BYTES (512) leaves the buffer unchanged and is not counted.
- R6: The status code is status_i[1:0]: 0 means no error, 1 means correctable, and 2 or 3 mean uncorrectable. The error count is status_i[13:8]. All other status bits have no effect.
- R7: An uncorrectable code sets fail_o, leaves the buffer unchanged and gives fixed_cnt_o of zero.
- R8: strength_i values 8, 16, 24 and 40 are used as given, and any other value acts as 16. A correctable status whose count exceeds the effective strength is handled as uncorrectable.
- R9: fixed_cnt_o equals the number of locations applied in the latest chunk and is cleared when each chunk starts.
- R10: done_o pulses for exactly one cycle per accepted start, and a start_i pulse while busy_o is high is ignored.
- R11: A buffer write while busy_o is high is ignored. Buffer reads are combinational at any time.
- R12: A no-error code leaves the buffer unchanged, with fixed_cnt_o of zero and fail_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin correcting the buffered chunk |
| status_i | input | 32 | Decoder status word: code in 1:0, count in 13:8 |
| strength_i | input | 8 | Configured correction strength in bits |
| loc_sel_o | output | 5 | Index of the requested location word |
| loc_word_i | input | 32 | Location word selected by loc_sel_o |
| buf_we_i | input | 1 | Buffer byte write enable |
| buf_addr_i | input | 9 | Buffer byte address |
| buf_wdata_i | input | 8 | Buffer write data |
| buf_rdata_o | output | 8 | Buffer read data at buf_addr_i |
| busy_o | output | 1 | Chunk in progress, including the done cycle |
| done_o | output | 1 | One-cycle end-of-chunk pulse |
| fixed_cnt_o | output | 6 | Bits flipped in the latest chunk |
| fail_o | output | 1 | Latest chunk was uncorrectable |

## Verification
A wrong remaining-count or word index shows up in the same run. Either fixed_cnt_o at the done pulse differs from the number of in-range locations, or a byte read back from the buffer carries a missing or extra inverted bit. A wrong first/second ordering or a wrong range decision shows up the same way, because each test chunk mixes odd and even counts, out-of-range positions and junk in the spare bits. A run that goes on too long or stops too early appears as a count mismatch or as an extra done_o pulse within the same chunk.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LO,
    ST_HI,
    ST_DONE
  } fix_state_e;

  localparam logic [1:0] CODE_CLEAN = 2'd0;
  localparam logic [1:0] CODE_FIX   = 2'd1;

  localparam int STR_DEFAULT = 16;

endpackage

// File: rtl/bch_strength_dec.sv
module bch_strength_dec #(
  parameter int CNT_W = 6
) (
  input  logic [7:0]       setting_i,
  output logic [CNT_W-1:0] cap_o
);
  import bch_fix_pkg::*;

  always_comb begin
    unique case (setting_i)
      8'd8:    cap_o = CNT_W'(8);
      8'd16:   cap_o = CNT_W'(16);
      8'd24:   cap_o = CNT_W'(24);
      8'd40:   cap_o = CNT_W'(40);
      default: cap_o = CNT_W'(STR_DEFAULT);
    endcase
  end

endmodule

// File: rtl/bch_loc_unpack.sv
module bch_loc_unpack #(
  parameter int LOC_W      = 13,
  parameter int UNIT_BYTES = 512,
  localparam int ADDR_W    = $clog2(UNIT_BYTES),
  localparam int BYTE_IX_W = LOC_W - 3
) (
  input  logic [LOC_W-1:0]  lo_i,
  input  logic [LOC_W-1:0]  hi_i,
  input  logic              sel_hi_i,
  output logic [ADDR_W-1:0] byte_o,
  output logic [2:0]        bit_o,
  output logic              in_range_o
);
  logic [LOC_W-1:0]     loc;
  logic [BYTE_IX_W-1:0] byte_full;

  assign loc        = sel_hi_i ? hi_i : lo_i;
  assign byte_full  = loc[LOC_W-1:3];
  assign bit_o      = loc[2:0];
  assign byte_o     = byte_full[ADDR_W-1:0];
  // one extra bit so a unit size of 2**BYTE_IX_W still compares correctly
  assign in_range_o = {1'b0, byte_full} < (BYTE_IX_W+1)'(UNIT_BYTES);

endmodule

// File: rtl/bch_chunk_buf.sv
module bch_chunk_buf #(
  parameter int UNIT_BYTES = 512,
  localparam int ADDR_W    = $clog2(UNIT_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              flip_en_i,
  input  logic [ADDR_W-1:0] flip_addr_i,
  input  logic [2:0]        flip_bit_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic [7:0] mem [UNIT_BYTES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i)
      mem[wr_addr_i] <= wr_data_i;
    else if (flip_en_i)
      mem[flip_addr_i] <= mem[flip_addr_i] ^ (8'd1 << flip_bit_i);
  end

  assign rd_data_o = mem[rd_addr_i];

  p_no_wr_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_en_i |-> !wr_en_i);

endmodule

// File: rtl/bch_bit_fixer.sv
module bch_bit_fixer #(
  parameter int UNIT_BYTES = 512,
  parameter int LOC_W      = 13,
  parameter int WORD_W     = 32,
  parameter int HI_LSB     = 16,
  parameter int CNT_LSB    = 8,
  parameter int MAX_STR    = 40,
  localparam int ADDR_W    = $clog2(UNIT_BYTES),
  localparam int CNT_W     = $clog2(MAX_STR + 1),
  localparam int WIDX_W    = $clog2((MAX_STR + 1) / 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       status_i,
  input  logic [7:0]        strength_i,
  output logic [WIDX_W-1:0] loc_sel_o,
  input  logic [WORD_W-1:0] loc_word_i,
  input  logic              buf_we_i,
  input  logic [ADDR_W-1:0] buf_addr_i,
  input  logic [7:0]        buf_wdata_i,
  output logic [7:0]        buf_rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  fixed_cnt_o,
  output logic              fail_o
);
  import bch_fix_pkg::*;

  fix_state_e        state_q;
  logic [WIDX_W-1:0] widx_q;
  logic [CNT_W-1:0]  left_q, fixed_q, cap_q, cap;
  logic [LOC_W-1:0]  lo_q, hi_q;
  logic              fail_q;

  logic [1:0]        code;
  logic [CNT_W-1:0]  n_err;
  logic              accept, bad;
  logic              applying, in_range, flip_en;
  logic [ADDR_W-1:0] flip_byte;
  logic [2:0]        flip_bit;

  logic unused_bits;
  assign unused_bits = ^{status_i[31:CNT_LSB+CNT_W], status_i[CNT_LSB-1:2],
                         loc_word_i[WORD_W-1:HI_LSB+LOC_W],
                         loc_word_i[HI_LSB-1:LOC_W]};

  assign code   = status_i[1:0];
  assign n_err  = status_i[CNT_LSB +: CNT_W];
  assign accept = start_i && (state_q == ST_IDLE);
  assign bad    = code[1] || ((code == CODE_FIX) && (n_err > cap));

  bch_strength_dec #(.CNT_W(CNT_W)) u_str (
    .setting_i (strength_i),
    .cap_o     (cap)
  );

  bch_loc_unpack #(.LOC_W(LOC_W), .UNIT_BYTES(UNIT_BYTES)) u_unpack (
    .lo_i       (lo_q),
    .hi_i       (hi_q),
    .sel_hi_i   (state_q == ST_HI),
    .byte_o     (flip_byte),
    .bit_o      (flip_bit),
    .in_range_o (in_range)
  );

  assign applying = (state_q == ST_LO) || (state_q == ST_HI);
  assign flip_en  = applying && in_range;

  bch_chunk_buf #(.UNIT_BYTES(UNIT_BYTES)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (buf_we_i && (state_q == ST_IDLE)),
    .wr_addr_i   (buf_addr_i),
    .wr_data_i   (buf_wdata_i),
    .flip_en_i   (flip_en),
    .flip_addr_i (flip_byte),
    .flip_bit_i  (flip_bit),
    .rd_addr_i   (buf_addr_i),
    .rd_data_o   (buf_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
      left_q  <= '0;
      fixed_q <= '0;
      cap_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      fail_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          fixed_q <= '0;
          cap_q   <= cap;
          widx_q  <= '0;
          left_q  <= n_err;
          fail_q  <= bad;
          if (bad || code == CODE_CLEAN || n_err == '0) state_q <= ST_DONE;
          else                                          state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          lo_q    <= loc_word_i[LOC_W-1:0];
          hi_q    <= loc_word_i[HI_LSB +: LOC_W];
          state_q <= ST_LO;
        end
        ST_LO, ST_HI: begin
          if (in_range) fixed_q <= fixed_q + CNT_W'(1);
          left_q <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1))   state_q <= ST_DONE;
          else if (state_q == ST_LO) state_q <= ST_HI;
          else begin
            widx_q  <= widx_q + WIDX_W'(1);
            state_q <= ST_FETCH;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign loc_sel_o   = widx_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign fixed_cnt_o = fixed_q;
  assign fail_o      = fail_q;

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_fail_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (fixed_cnt_o == '0));
  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fixed_cnt_o <= cap_q);
  p_cnt_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (fixed_cnt_o == '0));
  p_hi_after_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HI) |-> ($past(state_q) == ST_LO));
  p_fail_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !(start_i && !busy_o)) |=> fail_o);

endmodule

// File: tb/bch_bit_fixer_tb.sv
`timescale 1ns/1ps
module bch_bit_fixer_tb;
  localparam int UB = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] status_i = '0;
  logic [7:0]  strength_i = 8'd16;
  logic [4:0]  loc_sel_o;
  logic [31:0] loc_word_i;
  logic        buf_we_i = 1'b0;
  logic [8:0]  buf_addr_i = '0;
  logic [7:0]  buf_wdata_i = '0;
  logic [7:0]  buf_rdata_o;
  logic        busy_o, done_o, fail_o;
  logic [5:0]  fixed_cnt_o;

  logic [31:0] loc_bank [32];
  logic [7:0]  exp_mem [UB];

  typedef struct {int cnt; bit fail; string req;} exp_t;
  exp_t sb_q[$];

  int n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign loc_word_i = loc_bank[loc_sel_o];

  bch_bit_fixer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .status_i(status_i),
    .strength_i(strength_i), .loc_sel_o(loc_sel_o), .loc_word_i(loc_word_i),
    .buf_we_i(buf_we_i), .buf_addr_i(buf_addr_i), .buf_wdata_i(buf_wdata_i),
    .buf_rdata_o(buf_rdata_o), .busy_o(busy_o), .done_o(done_o),
    .fixed_cnt_o(fixed_cnt_o), .fail_o(fail_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input int lo, input int hi, input bit junk);
    logic [31:0] w;
    w = {3'b000, 13'(hi), 3'b000, 13'(lo)};
    if (junk) w = w | 32'hE000_E000;
    return w;
  endfunction

  function automatic int eff_str(input int s);
    if (s == 8 || s == 16 || s == 24 || s == 40) return s;
    return 16;
  endfunction

  // monitor: one expected item per done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done_o) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R10", "unexpected done pulse", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(fixed_cnt_o == 6'(e.cnt), e.req, "fixed count", fixed_cnt_o, e.cnt);
          check(fail_o == e.fail, e.req, "fail flag", fail_o, e.fail);
        end
      end
    end
  end

  task automatic compare_buf(input string req);
    int bad = 0, first = -1, act = 0, exv = 0;
    for (int a = 0; a < UB; a++) begin
      buf_addr_i = 9'(a);
      #0.1;
      if (buf_rdata_o !== exp_mem[a]) begin
        if (first < 0) begin first = a; act = buf_rdata_o; exv = exp_mem[a]; end
        bad++;
      end
    end
    check(bad == 0, req, $sformatf("buffer byte %0d", first), act, exv);
  endtask

  task automatic fill_buf(input int seed);
    for (int a = 0; a < UB; a++) begin
      @(negedge clk);
      buf_we_i = 1'b1; buf_addr_i = 9'(a); buf_wdata_i = 8'((a * 7 + seed) & 255);
      exp_mem[a] = 8'((a * 7 + seed) & 255);
    end
    @(negedge clk);
    buf_we_i = 1'b0;
  endtask

  // driver: models expectation, pushes it, runs the chunk
  task automatic run_chunk(input logic [31:0] st, input int str, input string req,
                           input bit disturb);
    int n, cap, cnt;
    bit fl;
    n   = int'(st[13:8]);
    cap = eff_str(str);
    fl  = st[1] || (st[1:0] == 2'd1 && n > cap);
    cnt = 0;
    if (st[1:0] == 2'd1 && !fl) begin
      for (int k = 0; k < n; k++) begin
        logic [31:0] w;
        int loc;
        w = loc_bank[k / 2];
        loc = (k % 2) ? int'(w[28:16]) : int'(w[12:0]);
        if ((loc >> 3) < UB) begin
          exp_mem[loc >> 3] = exp_mem[loc >> 3] ^ 8'(1 << (loc & 7));
          cnt++;
        end
      end
    end
    sb_q.push_back('{cnt, fl, req});
    @(negedge clk);
    status_i = st; strength_i = 8'(str); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      // R10 second start and R11 write while busy
      status_i = 32'h0000_0302; start_i = 1'b1;
      buf_we_i = 1'b1; buf_addr_i = 9'd5; buf_wdata_i = ~exp_mem[5];
      @(negedge clk);
      start_i = 1'b0; buf_we_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    @(negedge clk);
    compare_buf(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) loc_bank[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy_o == 1'b0 && done_o == 1'b0, "R1", "busy/done in reset", busy_o, 0);
    check(fail_o == 1'b0 && fixed_cnt_o == '0, "R1", "fail/count in reset", fixed_cnt_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0 && fixed_cnt_o == '0, "R1", "idle after reset", busy_o, 0);

    fill_buf(3);

    // R2 R3 R4: odd count of 1, second field must stay unused; junk bits set
    loc_bank[0] = pack(100, 200, 1'b1);
    run_chunk(32'h0000_0101, 16, "R3", 1'b0);

    // R2 R4: even count, both fields of two words, junk in spare status bits (R6)
    loc_bank[0] = pack(7, 4095, 1'b1);
    loc_bank[1] = pack(2048, 15, 1'b1);
    run_chunk(32'hA5A0_04FD, 16, "R2", 1'b0);

    // R4: count 3, second field of word 1 ignored
    loc_bank[0] = pack(33, 34, 1'b0);
    loc_bank[1] = pack(35, 3000, 1'b0);
    run_chunk(32'h0000_0301, 16, "R4", 1'b0);

    // R5: out-of-range locations skipped
    loc_bank[0] = pack(4096, 8191, 1'b0);
    loc_bank[1] = pack(4095, 0, 1'b0);
    run_chunk(32'h0000_0401, 16, "R5", 1'b0);

    // R7: uncorrectable codes 2 and 3
    loc_bank[0] = pack(50, 60, 1'b0);
    loc_bank[1] = pack(70, 80, 1'b0);
    run_chunk(32'h0000_0302, 16, "R7", 1'b0);
    run_chunk(32'h0000_0203, 16, "R7", 1'b0);

    // R12: clean code with nonzero count field
    run_chunk(32'h0000_0200, 16, "R12", 1'b0);

    // R8: strength limits; R9 count cleared per chunk
    for (int i = 0; i < 20; i++)
      loc_bank[i] = pack((i * 211 + 9) % 4600, (i * 97 + 500) % 4600, 1'b0);
    run_chunk(32'h0000_0901, 8, "R8", 1'b0);
    run_chunk(32'h0000_1801, 24, "R8", 1'b0);
    run_chunk(32'h0000_0001, 24, "R9", 1'b0);
    run_chunk(32'h0000_1101, 5, "R8", 1'b0);
    run_chunk(32'h0000_1001, 5, "R8", 1'b0);
    run_chunk(32'h0000_2801, 40, "R8", 1'b0);
    run_chunk(32'h0000_2901, 40, "R8", 1'b0);

    // R10 R11: restart and buffer write during a run are ignored
    run_chunk(32'h0000_0801, 16, "R11", 1'b1);
    check(sb_q.size() == 0, "R10", "pending expectations", sb_q.size(), 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule